// File: doc/BRIEF.md
# Branch Target Address Generator

This block produces the 32-bit branch target for a CPU whose program counter is 24 bits wide. Each computation is launched by a one-cycle `start` pulse. There are two ways to form the target.

In relative mode, a signed displacement of 8 or 16 bits is added to the address of the instruction that follows the branch. The sum wraps within 24 bits, and the top byte of the target is always zero.

In indirect mode, the low byte of the operand is zero-extended into a pointer into the low 256 bytes of memory. The target is then read through a synchronous 16-bit read port with one cycle of latency:
- With the address-width flag low, one word is read and that word is the target.
- With the flag high, two words are read: the high word at the pointer, then the low word at the pointer plus two. The most significant byte of the high word is discarded and replaced by zero.

An error flag travels with `done` whenever the target is odd. The target itself is still delivered unchanged.

Top module: `branch_target_gen`

## Requirements
- R1: In relative mode (`ind_mode`=0) with `long_disp`=0, `operand[7:0]` is sign-extended and added to `next_pc`. `done` is high in the cycle after the clock edge that samples `start`, with `target` = {8'h00, sum[23:0]}.
- R2: In relative mode with `long_disp`=1, all 16 bits of `operand` are sign-extended and added to `next_pc`, with the same timing as R1.
- R3: Every target has bits 31:24 equal to zero. A relative sum that leaves the 24-bit range wraps modulo 2^24.
- R4: In indirect mode with `wide_addr`=0, `mem_rd` is high in the cycle after `start` is sampled, with `mem_addr` = `operand[7:0]`. `done` is high two cycles later, with `target` = {16'h0000, word read}.
- R5: In indirect mode with `wide_addr`=1, the first read is at the pointer and the second read is in the next cycle at pointer+2 (modulo 256). `done` follows one cycle after the second read's data arrives, with `target` = {8'h00, first_word[7:0], second_word}.
- R6: `odd_err` is high exactly when `done` is high and `target[0]` is 1. The odd target is still presented on `target`.
- R7: A `start` that arrives while an indirect fetch is in progress is ignored. The fetch completes with its original result, and no extra `done` follows.
- R8: After reset, `done`, `odd_err` and `mem_rd` are low and `target` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches one computation |
| ind_mode | input | 1 | 1 = memory-indirect, 0 = PC-relative |
| long_disp | input | 1 | 1 = 16-bit displacement, 0 = 8-bit |
| wide_addr | input | 1 | 1 = two-word target fetch, 0 = one word |
| operand | input | 16 | Displacement, or pointer in bits 7:0 |
| next_pc | input | 24 | Address of the instruction after the branch |
| mem_rd | output | 1 | Read request to memory |
| mem_addr | output | 8 | Byte address of the requested word |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| target | output | 32 | Computed branch target |
| done | output | 1 | Target valid strobe |
| odd_err | output | 1 | Target is odd |

## Verification
The in-module assertions watch every cycle for the following:
- the zero top byte of each delivered target;
- the link between `odd_err` and `done`;
- the one-cycle turnaround of relative mode;
- the request that opens every indirect fetch;
- the +2 address step between the two reads of a wide fetch;
- the held pointer while a fetch is busy.

Only the bench's scenarios can show that the arithmetic values are right. This covers sign extension of both displacement sizes, 24-bit wraparound, the masking of the discarded byte, and the exact result and timing when a stray `start` lands in the middle of a fetch.

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
  parameter int PC_W  = 24,
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ind_mode,
  input  logic              long_disp,
  input  logic              wide_addr,
  input  logic [15:0]       operand,
  input  logic [PC_W-1:0]   next_pc,
  output logic              mem_rd,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic [15:0]       mem_rdata,
  output logic [31:0]       target,
  output logic              done,
  output logic              odd_err
);
  localparam int TOP_W = 32 - PC_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_CAP_A, S_CAP_B} st_t;
  st_t st;

  logic [PTR_W-1:0] ptr_q;
  logic             wide_q;
  logic [7:0]       hi_q;

  logic [15:0]     disp;
  logic [PC_W-1:0] rel_sum;
  logic [31:0]     rel_tgt;

  assign disp    = long_disp ? operand : {{8{operand[7]}}, operand[7:0]};
  assign rel_sum = next_pc + {{(PC_W-16){disp[15]}}, disp};
  assign rel_tgt = {{TOP_W{1'b0}}, rel_sum};

  assign mem_rd   = (st == S_REQ) || (st == S_CAP_A && wide_q);
  assign mem_addr = (st == S_CAP_A) ? ptr_q + PTR_W'(2) : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr_q   <= '0;
      wide_q  <= 1'b0;
      hi_q    <= '0;
      target  <= '0;
      done    <= 1'b0;
      odd_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      odd_err <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (ind_mode) begin
            ptr_q  <= operand[PTR_W-1:0];
            wide_q <= wide_addr;
            st     <= S_REQ;
          end else begin
            target  <= rel_tgt;
            done    <= 1'b1;
            odd_err <= rel_tgt[0];
          end
        end
        S_REQ: st <= S_CAP_A;
        S_CAP_A: begin
          if (wide_q) begin
            hi_q <= mem_rdata[7:0];
            st   <= S_CAP_B;
          end else begin
            target  <= {16'h0000, mem_rdata};
            done    <= 1'b1;
            odd_err <= mem_rdata[0];
            st      <= S_IDLE;
          end
        end
        default: begin
          target  <= {8'h00, hi_q, mem_rdata};
          done    <= 1'b1;
          odd_err <= mem_rdata[0];
          st      <= S_IDLE;
        end
      endcase
    end
  end

  p_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> target[31:24] == 8'h00);

  p_odd_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !odd_err);

  p_rel_turnaround_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !ind_mode) |=> done);

  p_ind_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && ind_mode) |=> (mem_rd && !done));

  p_second_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> mem_addr == $past(mem_addr) + PTR_W'(2));

  p_hold_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> ($stable(ptr_q) && $stable(wide_q)));
endmodule

// File: tb/branch_target_gen_tb.sv
module branch_target_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, ind_mode = 1'b0, long_disp = 1'b0, wide_addr = 1'b0;
  logic [15:0] operand = '0;
  logic [23:0] next_pc = '0;
  logic        mem_rd;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [31:0] target;
  logic        done, odd_err;
  logic [15:0] salt = 16'h1234;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ind_mode(ind_mode),
    .long_disp(long_disp), .wide_addr(wide_addr), .operand(operand),
    .next_pc(next_pc), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .target(target), .done(done), .odd_err(odd_err)
  );

  function automatic logic [15:0] memword(input logic [7:0] a);
    return {a ^ salt[7:0], (~a) + salt[15:8]};
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memword(mem_addr);

  function automatic logic [31:0] rel_exp(input logic [23:0] pc, input logic [15:0] op,
                                          input logic lng);
    logic [23:0] d;
    d = lng ? {{8{op[15]}}, op} : {{16{op[7]}}, op[7:0]};
    return {8'h00, pc + d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_rel(input logic [23:0] pc, input logic [15:0] op, input logic lng,
                         input string req);
    logic [31:0] e;
    e = rel_exp(pc, op, lng);
    start = 1; ind_mode = 0; long_disp = lng; operand = op; next_pc = pc;
    @(negedge clk);
    start = 0;
    chk({req, " done"}, {31'b0, done}, 32'd1);
    chk({req, " target"}, target, e);
    chk("R6 odd_err", {31'b0, odd_err}, {31'b0, e[0]});
    @(negedge clk);
    chk("R6 odd_err idle", {31'b0, odd_err}, 32'd0);
  endtask

  task automatic run_ind(input logic [7:0] ptr, input logic wide, input logic poke);
    logic [31:0] e;
    logic [7:0]  p2;
    p2 = ptr + 8'd2;
    e = wide ? {8'h00, memword(ptr)[7:0], memword(p2)} : {16'h0000, memword(ptr)};
    start = 1; ind_mode = 1; wide_addr = wide; operand = {$urandom_range(255), ptr};
    @(negedge clk);
    start = 0;
    chk("R4 first read request", {23'b0, mem_rd, mem_addr}, {23'b0, 1'b1, ptr});
    if (poke) begin
      start = 1; ind_mode = 0; operand = 16'h0001; next_pc = 24'h000010;
    end
    @(negedge clk);
    start = 0;
    if (poke) chk("R7 no done from stray start", {31'b0, done}, 32'd0);
    if (wide) begin
      chk("R5 second read at ptr+2", {23'b0, mem_rd, mem_addr}, {23'b0, 1'b1, p2});
      @(negedge clk);
      chk("R5 no early done", {31'b0, done}, 32'd0);
    end
    @(negedge clk);
    chk(wide ? "R5 done" : "R4 done", {31'b0, done}, 32'd1);
    chk(wide ? "R5 target" : "R4 target", target, e);
    chk("R6 odd_err", {31'b0, odd_err}, {31'b0, e[0]});
    chk("R3 top byte", {24'b0, target[31:24]}, 32'd0);
    @(negedge clk);
    if (poke) chk("R7 no extra done", {31'b0, done}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk("R8 reset done", {31'b0, done}, 32'd0);
    chk("R8 reset odd_err", {31'b0, odd_err}, 32'd0);
    chk("R8 reset mem_rd", {31'b0, mem_rd}, 32'd0);
    chk("R8 reset target", target, 32'd0);
    rst_n = 1;
    @(negedge clk);

    run_rel(24'h001000, 16'h0080, 0, "R1 min short");
    run_rel(24'h001000, 16'h007F, 0, "R1 max short");
    run_rel(24'h400000, 16'h8000, 1, "R2 min long");
    run_rel(24'h400000, 16'h7FFF, 1, "R2 max long");
    run_rel(24'hFFFFF0, 16'h0020, 0, "R3 wrap up");
    run_rel(24'h000004, 16'hFFF0, 1, "R3 wrap down");
    run_ind(8'h00, 0, 0);
    run_ind(8'hFE, 1, 0);
    run_ind(8'h40, 0, 1);
    run_ind(8'h80, 1, 1);

    for (int i = 0; i < 300; i++) begin
      salt = 16'($urandom);
      case ($urandom_range(3))
        0: run_rel(24'($urandom), 16'($urandom), 0, "R1 random");
        1: run_rel(24'($urandom), 16'($urandom), 1, "R2 random");
        2: run_ind(8'($urandom), 0, 1'($urandom_range(1)));
        default: run_ind(8'($urandom), 1, 1'($urandom_range(1)));
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule